// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous cache RAM that supports bursts. An external address is captured whenever either of two active-low load strobes is seen low at a rising clock edge. One strobe comes from the processor side and the other from the cache controller side. Once an address is loaded, the advance input steps through the four words of the aligned group. Only the two low address bits change. The upper bits keep the value that was loaded.

A static mode input picks the stepping order. Linear order adds the beat count to the loaded low bits, modulo four. Interleaved order XORs the beat count into the loaded low bits. The active-low chip enable gates the strobes. With the chip disabled, a processor strobe is ignored, but a controller strobe deselects the block. All inputs except the mode pin are captured on the rising clock edge. The mode pin acts on the output combinationally.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_o is all zeros and valid_o is 0.
- R2: When proc_strb_ni is 0 and ce_ni is 0 at a rising edge, addr_o equals the sampled addr_i and valid_o is 1 after that edge.
- R3: When ctrl_strb_ni is 0 and ce_ni is 0 at a rising edge, addr_o equals the sampled addr_i and valid_o is 1 after that edge.
- R4: When proc_strb_ni is 0, ce_ni is 1, ctrl_strb_ni is 1 and adv_ni is 1 at an edge, addr_o and valid_o do not change.
- R5: When ctrl_strb_ni is 0 and ce_ni is 1 at an edge, valid_o becomes 0 and addr_o keeps its value.
- R6: With interleave_i = 0, each edge with adv_ni = 0, valid_o = 1 and no load sets addr_o[1:0] to (loaded low bits + beats) mod 4.
- R7: With interleave_i = 1, the same stepping sets addr_o[1:0] to the loaded low bits XOR (beats mod 4).
- R8: During a burst, addr_o[ADDR_W-1:2] never changes. After four advances, addr_o returns to the loaded address.
- R9: A load and an advance at the same edge act as a load alone: addr_o equals the new addr_i and the beat count restarts at zero.
- R10: An advance while valid_o is 0 has no effect on addr_o.
- R11: interleave_i is not registered. A change on it alters addr_o[1:0] without a clock edge.
- R12: An edge with adv_ni = 1 and no strobe action leaves addr_o and valid_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| proc_strb_ni | input | 1 | Processor-side load strobe, active low, gated by ce_ni |
| ctrl_strb_ni | input | 1 | Controller-side load strobe, active low; deselects the block when ce_ni is high |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| interleave_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |
| valid_o | output | 1 | Block selected and holding a loaded address |

## Verification
The assertions check, on every cycle, that the beat counter clears on a load, steps by one on an advance and holds otherwise. They also check that an enabled strobe loads the sampled address, that a gated processor strobe changes nothing, that a controller strobe with the chip disabled deselects, and that the upper bits hold whenever no load takes place. Only the bench scenarios can show the actual low-bit sequences: linear and interleaved order from every start offset, wrap after four beats, a load winning over an advance, and the combinational effect of the mode pin between edges.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DESEL = 2'd2,
    ACT_STEP  = 2'd3
  } seq_act_e;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import burst_seq_pkg::*;
(
  input  logic     proc_strb_ni,
  input  logic     ctrl_strb_ni,
  input  logic     adv_ni,
  input  logic     ce_ni,
  input  logic     valid_i,
  output seq_act_e act_o
);
  always_comb begin
    act_o = ACT_HOLD;
    if (!ce_ni && (!proc_strb_ni || !ctrl_strb_ni)) act_o = ACT_LOAD;
    else if (ce_ni && !ctrl_strb_ni)                 act_o = ACT_DESEL;
    else if (!adv_ni && valid_i)                     act_o = ACT_STEP;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  output logic [BURST_W-1:0] cnt_o
);
  logic [BURST_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_load_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_step_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i) |=> cnt_q == BURST_W'($past(cnt_q) + 1'b1));
  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int unsigned BURST_W = 2
) (
  input  logic [BURST_W-1:0] base_lo_i,
  input  logic [BURST_W-1:0] cnt_i,
  input  logic               interleave_i,
  output logic [BURST_W-1:0] lo_o
);
  logic [BURST_W-1:0] lin_lo, ilv_lo;

  assign lin_lo = base_lo_i + cnt_i;  // wraps, no carry out
  assign ilv_lo = base_lo_i ^ cnt_i;
  assign lo_o   = interleave_i ? ilv_lo : lin_lo;

  always_comb begin
    if (cnt_i == '0) begin
      assert_first_beat_R8: assert (lo_o == base_lo_i);
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              adv_ni,
  input  logic              ce_ni,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  seq_act_e           act;
  logic [ADDR_W-1:0]  base_q;
  logic               valid_q;
  logic [BURST_W-1:0] cnt, lo;

  strobe_decode u_dec (
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .adv_ni       (adv_ni),
    .ce_ni        (ce_ni),
    .valid_i      (valid_q),
    .act_o        (act)
  );

  burst_counter #(.BURST_W(BURST_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (act == ACT_LOAD),
    .step_i (act == ACT_STEP),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          base_q  <= addr_i;
          valid_q <= 1'b1;
        end
        ACT_DESEL: valid_q <= 1'b0;
        default: ;
      endcase
    end
  end

  burst_order #(.BURST_W(BURST_W)) u_ord (
    .base_lo_i    (base_q[BURST_W-1:0]),
    .cnt_i        (cnt),
    .interleave_i (interleave_i),
    .lo_o         (lo)
  );

  assign addr_o  = {base_q[ADDR_W-1:BURST_W], lo};
  assign valid_o = valid_q;

  assert_proc_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !proc_strb_ni) |=> valid_o && addr_o == $past(addr_i));
  assert_ctrl_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !ctrl_strb_ni) |=> valid_o && addr_o == $past(addr_i));
  assert_proc_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && ctrl_strb_ni && adv_ni) |=> $stable(addr_o) && $stable(valid_o));
  assert_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !ctrl_strb_ni) |=> !valid_o && $stable(addr_o));
  assert_upper_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || (proc_strb_ni && ctrl_strb_ni)) |=> $stable(addr_o[ADDR_W-1:BURST_W]));
  assert_no_step_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && proc_strb_ni && ctrl_strb_ni) |=> $stable(addr_o) && !valid_o);

  if (HI_W < 1) begin : g_bad_width
    initial assert_width_ok: assert (0);
  end
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int MAX_CYC = 200000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          proc_strb_ni = 1'b1, ctrl_strb_ni = 1'b1, adv_ni = 1'b1, ce_ni = 1'b0;
  logic          interleave_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          valid_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_valid = 1'b0;
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_addr_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .proc_strb_ni(proc_strb_ni), .ctrl_strb_ni(ctrl_strb_ni),
    .adv_ni(adv_ni), .ce_ni(ce_ni), .interleave_i(interleave_i),
    .addr_o(addr_o), .valid_o(valid_o)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = interleave_i ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (addr_o !== exp_addr() || valid_o !== m_valid) begin
      errors++;
      $display("FAIL %s: addr_o=%h valid_o=%b expected addr=%h valid=%b",
               tag, addr_o, valid_o, exp_addr(), m_valid);
    end
  endtask

  function automatic logic [AW-1:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[AW-1:0];
  endfunction

  // drive after a negedge, model the rising edge, check at the next negedge
  task automatic cyc(input logic p, input logic c, input logic a, input logic e,
                     input logic [AW-1:0] ad, input string tag);
    proc_strb_ni = p; ctrl_strb_ni = c; adv_ni = a; ce_ni = e; addr_i = ad;
    @(negedge clk_i);
    if (!e && (!p || !c)) begin
      m_base = ad; m_cnt = '0; m_valid = 1'b1;
    end else if (e && !c) begin
      m_valid = 1'b0;
    end else if (!a && m_valid) begin
      m_cnt = m_cnt + 2'd1;
    end
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");

    // order sweep: both modes, every start offset, both strobes, with wrap
    for (int md = 0; md < 2; md++) begin
      interleave_i = md[0];
      for (int st = 0; st < 4; st++) begin
        for (int sb = 0; sb < 2; sb++) begin
          logic [AW-1:0] ad;
          ad = {next_rand()} & ~18'h3 | AW'(st);
          if (sb == 0) cyc(1'b0, 1'b1, 1'b1, 1'b0, ad, "R2 proc load");
          else         cyc(1'b1, 1'b0, 1'b1, 1'b0, ad, "R3 ctrl load");
          for (int b = 1; b <= 5; b++) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0, next_rand(), md ? "R7 interleaved step" : "R6 linear step");
            if (b == 2) cyc(1'b1, 1'b1, 1'b1, 1'b0, next_rand(), "R12 hold");
            if (b == 4 && addr_o !== ad) begin
              errors++;
              $display("FAIL R8 wrap: addr_o=%h expected=%h", addr_o, ad);
            end
            if (b == 4) checks++;
          end
        end
      end
    end

    // load beats advance in the same cycle
    interleave_i = 1'b0;
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 18'h2AB41, "R2 load");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6 step");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6 step");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 18'h13C82, "R9 proc load with advance");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R9 count restarted");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 18'h00F23, "R9 ctrl load with advance");

    // gated processor strobe
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 18'h3FFFF, "R4 proc strobe ignored");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 18'h11111, "R4 proc strobe ignored again");

    // controller deselect, then advances do nothing
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6 step");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 18'h22222, "R5 deselect");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R10 advance while deselected");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, '0, "R10 advance while deselected");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 18'h0ABC5, "R2 reload");

    // mode pin acts without a clock edge: start 1, 3 beats -> linear 0, interleaved 2
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6 step");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6 step");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6 step");
    adv_ni = 1'b1;
    checks++;
    if (addr_o[1:0] !== 2'd0) begin
      errors++; $display("FAIL R11 linear: low=%0d expected=0", addr_o[1:0]);
    end
    interleave_i = 1'b1;
    #1;
    checks++;
    if (addr_o[1:0] !== 2'd2) begin
      errors++; $display("FAIL R11 interleaved: low=%0d expected=2", addr_o[1:0]);
    end
    interleave_i = 1'b0;
    #1;

    // mixed control sweep
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] r;
      r = next_rand();
      if (i == 200) interleave_i = 1'b1;
      cyc(r[3], r[5], r[7] & r[8], r[10] & r[11], next_rand(), "R2 R3 R4 R5 R6 R7 R10 mix");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule